// File: doc/BRIEF.md
# Idle Mode Clock Gating Controller

This block decides which clock enables a small microcontroller core receives while it sleeps in idle mode. Software enters idle by writing a control word with the sleep bit set. From the next clock edge the CPU clock enable is withdrawn. The peripheral clock enables keep running, so timers, serial ports and capture logic can go on working and later raise an interrupt. The watchdog clock enable is handled separately. It keeps running in idle only if the watchdog-in-idle bit was set in the last accepted control write.

The block leaves idle when an interrupt line is pending and its enable bit is also set. A pending line whose enable bit is clear is ignored. The sleep condition clears itself in hardware. The CPU clock enable returns on the next edge, and a one-cycle wake pulse tells the interrupt logic to service the request at once. After that service, execution continues after the instruction that entered idle. Reset ends idle in any state.

The core is a three-state machine:
- ST_RUN is normal execution.
- ST_IDLE means the CPU clock is gated.
- ST_WAKE is the single exit cycle that carries the wake pulse.

The transitions are:
- ENTER: from ST_RUN or ST_WAKE to ST_IDLE, on an accepted write with bit 0 set.
- EXIT: from ST_IDLE to ST_WAKE, on an enabled pending interrupt.
- RESUME: from ST_WAKE to ST_RUN, when the wake cycle ends with no new entry.
- RESET: from any state to ST_RUN.

Top module: `idle_clkgate_ctrl`

## Requirements
- R1: A write strobe in ST_RUN or ST_WAKE with control bit 0 (sleep) set makes idle_flag 1 and cpu_clk_en 0 from the next clock edge.
- R2: per_clk_en is all ones in every state, including idle.
- R3: Outside idle, wdt_clk_en is 1. In idle it equals control bit 1 (watchdog-in-idle) of the last accepted write.
- R4: In idle, if any bit of irq_pend AND irq_en is 1, then on the next edge idle_flag returns to 0 and cpu_clk_en returns to 1.
- R5: In idle, pending lines whose enable bit is 0 never end idle.
- R6: An interrupt exit drives wake_pulse to 1 for exactly one cycle, the first cycle after the exit. At all other times it is 0.
- R7: Reset (rst_n low, asynchronous) forces ST_RUN: cpu_clk_en is 1, idle_flag is 0, wake_pulse is 0 and the watchdog-in-idle bit is 0. This also ends idle.
- R8: Write strobes that arrive while in idle are ignored. The watchdog-in-idle bit and the idle state do not change.
- R9: A write with bit 0 clear updates the watchdog-in-idle bit and leaves the block running.
- R10: A write accepted in the ST_WAKE cycle is honoured just as in ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Write data; bit 0 sleep, bit 1 watchdog-in-idle |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enable mask |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | N_PER | Peripheral clock enables |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| idle_flag | output | 1 | High while in idle |
| wake_pulse | output | 1 | One-cycle pulse on interrupt exit |

## Verification
All outputs are Moore functions of the state register, so a wrong state shows at the ports one edge after it arises. A missed exit leaves cpu_clk_en low and wake_pulse absent in the cycle that follows an enabled interrupt. A spurious entry or exit flips idle_flag and cpu_clk_en at once. A corrupted watchdog-in-idle bit stays hidden until the next idle period, where wdt_clk_en gives it away in the first idle cycle. The bench runs a behavioural model next to the design and compares every output on every cycle, through directed and random interrupt, mask and write traffic.

// File: rtl/idle_clkgate_pkg.sv
package idle_clkgate_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAKE = 2'd2
    } idle_state_e;
endpackage

// File: rtl/idle_irq_qual.sv
module idle_irq_qual #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             wake_req
);
    logic [N_IRQ-1:0] live;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign live[i] = irq_pend[i] & irq_en[i];
    end

    assign wake_req = |live;
endmodule

// File: rtl/idle_ctl_reg.sv
module idle_ctl_reg #(
    parameter int CTL_W   = 8,
    parameter int WDI_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [CTL_W-1:0] wdata,
    output logic             wd_in_idle
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_in_idle <= 1'b0;
        end else if (wr_accept) begin
            wd_in_idle <= wdata[WDI_BIT];
        end
    end
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import idle_clkgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic sleep_req,
    input  logic wake_req,
    output logic wr_accept,
    output logic cpu_run,
    output logic in_idle,
    output logic wake
);
    idle_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN, ST_WAKE: begin
                if (ctl_wr && sleep_req) state_nx = ST_IDLE;
                else                     state_nx = ST_RUN;
            end
            ST_IDLE: begin
                if (wake_req) state_nx = ST_WAKE;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        wr_accept = 1'b0;
        cpu_run   = 1'b1;
        in_idle   = 1'b0;
        wake      = 1'b0;
        unique case (state)
            ST_RUN: begin
                wr_accept = ctl_wr;
            end
            ST_IDLE: begin
                cpu_run = 1'b0;
                in_idle = 1'b1;
            end
            ST_WAKE: begin
                wr_accept = ctl_wr;
                wake      = 1'b1;
            end
            default: begin
                cpu_run = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/idle_clkgate_ctrl.sv
module idle_clkgate_ctrl #(
    parameter int CTL_W     = 8,
    parameter int N_IRQ     = 8,
    parameter int N_PER     = 5,
    parameter int SLEEP_BIT = 0,
    parameter int WDI_BIT   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             cpu_clk_en,
    output logic [N_PER-1:0] per_clk_en,
    output logic             wdt_clk_en,
    output logic             idle_flag,
    output logic             wake_pulse
);
    localparam logic [N_PER-1:0] PER_ALL = {N_PER{1'b1}};

    logic wake_req;
    logic wr_accept;
    logic wd_in_idle;

    idle_irq_qual #(.N_IRQ(N_IRQ)) u_qual (
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .wake_req (wake_req)
    );

    idle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .sleep_req (ctl_wdata[SLEEP_BIT]),
        .wake_req  (wake_req),
        .wr_accept (wr_accept),
        .cpu_run   (cpu_clk_en),
        .in_idle   (idle_flag),
        .wake      (wake_pulse)
    );

    idle_ctl_reg #(.CTL_W(CTL_W), .WDI_BIT(WDI_BIT)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_accept  (wr_accept),
        .wdata      (ctl_wdata),
        .wd_in_idle (wd_in_idle)
    );

    assign per_clk_en = PER_ALL;
    assign wdt_clk_en = !idle_flag || wd_in_idle;
endmodule

// File: rtl/idle_clkgate_chk.sv
module idle_clkgate_chk #(
    parameter int CTL_W     = 8,
    parameter int N_IRQ     = 8,
    parameter int SLEEP_BIT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic [CTL_W-1:0] ctl_wdata,
    input logic [N_IRQ-1:0] irq_pend,
    input logic [N_IRQ-1:0] irq_en,
    input logic             cpu_clk_en,
    input logic             wdt_clk_en,
    input logic             idle_flag,
    input logic             wake_pulse
);
    p_enter_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_flag && ctl_wr && ctl_wdata[SLEEP_BIT]) |=> (idle_flag && !cpu_clk_en));

    p_wdt_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_flag |-> wdt_clk_en);

    p_irq_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && |(irq_pend & irq_en)) |=> (!idle_flag && cpu_clk_en));

    p_masked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !(|(irq_pend & irq_en))) |=> idle_flag);

    p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    p_wake_after_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> $past(idle_flag));

    p_idle_ignores_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && $past(idle_flag)) |-> $stable(wdt_clk_en));
endmodule

bind idle_clkgate_ctrl idle_clkgate_chk #(
    .CTL_W(CTL_W), .N_IRQ(N_IRQ), .SLEEP_BIT(SLEEP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .irq_pend(irq_pend), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en),
    .wdt_clk_en(wdt_clk_en), .idle_flag(idle_flag), .wake_pulse(wake_pulse)
);

// File: tb/idle_clkgate_ctrl_tb.sv
module idle_clkgate_ctrl_tb;
    localparam int CTL_W = 8;
    localparam int N_IRQ = 8;
    localparam int N_PER = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [CTL_W-1:0] ctl_wdata = '0;
    logic [N_IRQ-1:0] irq_pend = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             cpu_clk_en, wdt_clk_en, idle_flag, wake_pulse;
    logic [N_PER-1:0] per_clk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit m_idle = 1'b0;
    bit m_wake = 1'b0;
    bit m_wd   = 1'b0;

    always #4 clk = ~clk;

    idle_clkgate_ctrl #(.CTL_W(CTL_W), .N_IRQ(N_IRQ), .N_PER(N_PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .irq_pend(irq_pend), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .wdt_clk_en(wdt_clk_en),
        .idle_flag(idle_flag), .wake_pulse(wake_pulse)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idle = 1'b0; m_wake = 1'b0; m_wd = 1'b0;
        end else if (m_idle) begin
            m_wake = 1'b0;
            if ((irq_pend & irq_en) != 0) begin
                m_idle = 1'b0; m_wake = 1'b1;
            end
        end else begin
            m_wake = 1'b0;
            if (ctl_wr) begin
                m_wd = ctl_wdata[1];
                if (ctl_wdata[0]) m_idle = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R1/R4/R7 idle_flag", {7'd0, idle_flag}, {7'd0, m_idle});
            chk("R1/R4/R7 cpu_clk_en", {7'd0, cpu_clk_en}, {7'd0, !m_idle});
            chk("R2 per_clk_en", {3'd0, per_clk_en}, 8'h1F);
            chk("R3/R8/R9 wdt_clk_en", {7'd0, wdt_clk_en}, {7'd0, (!m_idle) || m_wd});
            chk("R6 wake_pulse", {7'd0, wake_pulse}, {7'd0, m_wake});
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        tick(1);
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    initial begin
        tick(2);
        // R7: reset state
        chk("R7 reset cpu_clk_en", {7'd0, cpu_clk_en}, 8'd1);
        chk("R7 reset idle_flag", {7'd0, idle_flag}, 8'd0);
        rst_n = 1'b1;
        tick(2);
        // R9: write without sleep bit keeps running
        wr(8'h02);
        tick(1);
        chk("R9 still running", {7'd0, idle_flag}, 8'd0);
        // R1, R3: enter idle with watchdog kept
        wr(8'h03);
        chk("R1 entered idle", {7'd0, idle_flag}, 8'd1);
        chk("R3 wdt on in idle", {7'd0, wdt_clk_en}, 8'd1);
        // R5: masked pending
        irq_pend = 8'h10; irq_en = 8'h01;
        tick(4);
        chk("R5 masked no wake", {7'd0, idle_flag}, 8'd1);
        // R8: write while idle ignored
        wr(8'h00);
        chk("R8 wd bit kept", {7'd0, wdt_clk_en}, 8'd1);
        // R4, R6: enabled interrupt wakes
        irq_en = 8'h10;
        tick(1);
        chk("R4 woke", {7'd0, cpu_clk_en}, 8'd1);
        chk("R6 pulse", {7'd0, wake_pulse}, 8'd1);
        irq_pend = '0;
        // R10: write during wake cycle re-enters idle, watchdog gated
        wr(8'h01);
        chk("R10 re-entry", {7'd0, idle_flag}, 8'd1);
        chk("R3 wdt gated", {7'd0, wdt_clk_en}, 8'd0);
        tick(3);
        // R7: reset ends idle
        rst_n = 1'b0;
        tick(1);
        chk("R7 reset exits idle", {7'd0, idle_flag}, 8'd0);
        rst_n = 1'b1;
        tick(1);
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            ctl_wr    = ($urandom_range(0, 3) == 0);
            ctl_wdata = 8'($urandom);
            irq_pend  = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
            irq_en    = 8'($urandom);
            tick(1);
        end
        ctl_wr = 1'b0; irq_pend = '0;
        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule